// File: doc/BRIEF.md
# 12-bit ALU with Zero/Negative Flags

This block is the arithmetic-logic stage of a small 12-bit datapath. Two 12-bit operands and a four-bit operation code enter, and a 12-bit result leaves through combinational logic in the same cycle. Every result wraps modulo 4096. Beside the result, the block keeps two status bits, zero and negative, in registers. They take a new value only on a clock edge where the update strobe is high and the operation code names a real operation.

The low operation codes 1 to 7 match the three-bit major field of the three-operand instructions. Codes 8 to 11 select the single-source operations, which use only operand A. Memory, pointer and branch instructions drive the update strobe low, so the flags they find are the ones the last ALU operation left. A code with no operation gives a zero result and never disturbs the flags.

Top module: `alu12`

## Requirements
- R1: Code 1 gives A AND B, code 2 gives A OR B and code 4 gives A XOR B.
- R2: Code 5 gives the bitwise inverse of A OR B, and code 6 gives the bitwise inverse of A AND B.
- R3: Code 7 gives A + B modulo 4096, so 0x800 + 0x800 = 0x000.
- R4: Code 3 gives A + (inverse of B) + 1 modulo 4096, which equals A - B wrapped, so 0x000 - 0x001 = 0xFFF.
- R5: Code 8 shifts A left by one and drops bit 11. Code 9 shifts A right by one, logically, with a zero entering bit 11. B is ignored.
- R6: Code 10 gives A + 1 and code 11 gives A - 1, both modulo 4096, so 0xFFF + 1 = 0x000 and 0x000 - 1 = 0xFFF. B is ignored.
- R7: Codes 0 and 12 to 15 give a result of 0x000 and leave both flags unchanged even when upd_i is high.
- R8: On a rising clock edge with upd_i high and a valid code (1 to 11), zero_o is loaded with 1 exactly when the result is 0x000.
- R9: On the same kind of edge, neg_o is loaded with bit 11 of the result.
- R10: On a rising clock edge with upd_i low, zero_o and neg_o keep their values.
- R11: While rst_ni is low, zero_o and neg_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the flag registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 12 | Operand A |
| b_i | input | 12 | Operand B (three-operand codes only) |
| upd_i | input | 1 | Flag update strobe |
| res_o | output | 12 | Combinational result |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |

## Verification
The result is combinational. It is due in the same cycle as its operands, so the bench drives each vector on a falling edge and compares res_o a quarter period later, before any rising edge. The flags are due one rising edge after the strobe. The bench therefore holds the vector and the strobe across exactly one rising edge and samples zero_o and neg_o a quarter period after that edge. In the checks of the hold and unused-code cases, the flags are first loaded with a known value, and then the bench confirms after the next edge that they kept it.

// File: rtl/alu12_pkg.sv
package alu12_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_SUB  = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOR  = 4'd5,
    OP_NAND = 4'd6,
    OP_ADD  = 4'd7,
    OP_LSH  = 4'd8,
    OP_RSH  = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_ARITH = 2'd2,
    GRP_SHIFT = 2'd3
  } alu_grp_e;

  function automatic alu_grp_e op_group(alu_op_e op);
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOR, OP_NAND: op_group = GRP_LOGIC;
      OP_ADD, OP_SUB, OP_INC, OP_DEC:         op_group = GRP_ARITH;
      OP_LSH, OP_RSH:                         op_group = GRP_SHIFT;
      default:                                op_group = GRP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/alu12_logic.sv
module alu12_logic
  import alu12_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] and_v, or_v, xor_v;
  logic             inv;

  assign and_v = a_i & b_i;
  assign or_v  = a_i | b_i;
  assign xor_v = a_i ^ b_i;
  assign inv   = (op_i == OP_NOR) || (op_i == OP_NAND);

  logic [WIDTH-1:0] base;
  always_comb begin
    case (op_i)
      OP_AND, OP_NAND: base = and_v;
      OP_OR,  OP_NOR:  base = or_v;
      OP_XOR:          base = xor_v;
      default:         base = '0;
    endcase
  end

  // inverted forms reuse the plain gate outputs through a mask
  assign res_o = base ^ (inv ? ALL_ONES : '0);

endmodule

// File: rtl/alu12_arith.sv
module alu12_arith
  import alu12_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] addend;
  logic             cin;

  // one adder: SUB = a + ~b + 1, INC = a + 0 + 1, DEC = a + all-ones
  always_comb begin
    case (op_i)
      OP_ADD:  begin addend = b_i;            cin = 1'b0; end
      OP_SUB:  begin addend = b_i ^ ALL_ONES; cin = 1'b1; end
      OP_INC:  begin addend = '0;             cin = 1'b1; end
      OP_DEC:  begin addend = ALL_ONES;       cin = 1'b0; end
      default: begin addend = '0;             cin = 1'b0; end
    endcase
  end

  assign res_o = a_i + addend + (cin ? ONE : '0);

endmodule

// File: rtl/alu12_shift.sv
module alu12_shift
  import alu12_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] res_o
);

  always_comb begin
    case (op_i)
      OP_LSH:  res_o = {a_i[WIDTH-2:0], 1'b0};
      OP_RSH:  res_o = {1'b0, a_i[WIDTH-1:1]};
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu12_flags.sv
module alu12_flags #(
  parameter int WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o,
  output logic             neg_o
);

  localparam int MSB = WIDTH - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_o <= 1'b0;
      neg_o  <= 1'b0;
    end else if (load_i) begin
      zero_o <= (res_i == '0);
      neg_o  <= res_i[MSB];
    end
  end

endmodule

// File: rtl/alu12.sv
module alu12
  import alu12_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             upd_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             neg_o
);

  alu_op_e          op;
  alu_grp_e         grp;
  logic [WIDTH-1:0] logic_res, arith_res, shift_res;

  assign op  = alu_op_e'(op_i);
  assign grp = op_group(op);

  alu12_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(logic_res)
  );

  alu12_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(arith_res)
  );

  alu12_shift #(.WIDTH(WIDTH)) u_shift (
    .op_i (op),
    .a_i  (a_i),
    .res_o(shift_res)
  );

  always_comb begin
    case (grp)
      GRP_LOGIC: res_o = logic_res;
      GRP_ARITH: res_o = arith_res;
      GRP_SHIFT: res_o = shift_res;
      default:   res_o = '0;
    endcase
  end

  alu12_flags #(.WIDTH(WIDTH)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(upd_i && (grp != GRP_NONE)),
    .res_i (res_o),
    .zero_o(zero_o),
    .neg_o (neg_o)
  );

endmodule

// File: rtl/alu12_chk.sv
module alu12_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             upd_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             neg_o
);

  localparam int MSB = WIDTH - 1;

  logic code_ok;
  assign code_ok = (op_i >= 4'd1) && (op_i <= 4'd11);

  p_add_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |-> (res_o == WIDTH'(a_i + b_i)));

  p_sub_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3) |-> (res_o == WIDTH'(a_i - b_i)));

  p_inc_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10) |-> (res_o == WIDTH'(a_i + 1)));

  p_unused_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_ok |-> (res_o == '0));

  p_zero_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && code_ok) |=> (zero_o == ($past(res_o) == '0)));

  p_neg_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && code_ok) |=> (neg_o == $past(res_o[MSB])));

  p_flag_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && code_ok) |=> ($stable(zero_o) && $stable(neg_o)));

  always_comb begin
    if (!rst_ni) begin
      a_reset_clear_r11: assert (!zero_o && !neg_o);
    end
  end

endmodule

bind alu12 alu12_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu12_test.sv
module alu12_test;

  localparam int W = 12;
  localparam int NV = 15;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         upd_i = 1'b0;
  logic [W-1:0] res_o;
  logic         zero_o, neg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  alu12 #(.WIDTH(W)) uut (.*);

  // {op, a, b, expected}
  localparam logic [39:0] VEC [NV] = '{
    {4'd1,  12'hF0F, 12'h0FF, 12'h00F},
    {4'd2,  12'hF00, 12'h0F0, 12'hFF0},
    {4'd4,  12'hAAA, 12'hFFF, 12'h555},
    {4'd4,  12'h3C3, 12'h3C3, 12'h000},
    {4'd5,  12'h0F0, 12'h00F, 12'hF00},
    {4'd6,  12'hFFF, 12'hFFF, 12'h000},
    {4'd6,  12'h0F0, 12'h00F, 12'hFFF},
    {4'd7,  12'h800, 12'h800, 12'h000},
    {4'd7,  12'h123, 12'h456, 12'h579},
    {4'd3,  12'h005, 12'h003, 12'h002},
    {4'd3,  12'h000, 12'h001, 12'hFFF},
    {4'd8,  12'hC01, 12'h5A5, 12'h802},
    {4'd9,  12'h801, 12'hFFF, 12'h400},
    {4'd10, 12'hFFF, 12'h123, 12'h000},
    {4'd11, 12'h000, 12'h777, 12'hFFF}
  };

  function automatic string op_tag(logic [3:0] op);
    case (op)
      4'd1, 4'd2, 4'd4: op_tag = "R1";
      4'd5, 4'd6:       op_tag = "R2";
      4'd7:             op_tag = "R3";
      4'd3:             op_tag = "R4";
      4'd8, 4'd9:       op_tag = "R5";
      4'd10, 4'd11:     op_tag = "R6";
      default:          op_tag = "R7";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive on falling edge, optionally pass one rising edge with the strobe
  task automatic apply(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b, logic upd);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; upd_i = upd;
    #5;
  endtask

  task automatic pass_edge();
    @(posedge clk_i);
    #5;
    upd_i = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: flags clear in reset
    #25;
    check("R11", "zero in reset", {11'd0, zero_o}, 12'd0);
    check("R11", "neg in reset", {11'd0, neg_o}, 12'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0]   op;
      logic [W-1:0] a, b, e;
      {op, a, b, e} = VEC[i];
      apply(op, a, b, 1'b1);
      check(op_tag(op), "result", res_o, e);
      pass_edge();
      check("R8", "zero flag", {11'd0, zero_o}, {11'd0, (e == '0)});
      check("R9", "neg flag", {11'd0, neg_o}, {11'd0, e[W-1]});
    end

    // R10: load zero=1 neg=0, then strobe low with a negative nonzero result
    apply(4'd7, 12'h000, 12'h000, 1'b1);
    pass_edge();
    apply(4'd7, 12'h900, 12'h001, 1'b0);
    check("R3", "result with strobe low", res_o, 12'h901);
    pass_edge();
    check("R10", "zero held", {11'd0, zero_o}, 12'd1);
    check("R10", "neg held", {11'd0, neg_o}, 12'd0);

    // R7: unused codes give zero and leave flags alone even with strobe high
    apply(4'd11, 12'h000, 12'h000, 1'b1); // zero=0 neg=1
    pass_edge();
    check("R9", "neg set by dec", {11'd0, neg_o}, 12'd1);
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c >= 12) begin
        apply(c[3:0], 12'hABC, 12'h123, 1'b1);
        check("R7", "unused result", res_o, 12'h000);
        pass_edge();
        check("R7", "zero untouched", {11'd0, zero_o}, 12'd0);
        check("R7", "neg untouched", {11'd0, neg_o}, 12'd1);
      end
    end

    // R5/R6: B has no effect on single-source codes
    apply(4'd8, 12'h001, 12'hFFF, 1'b0);
    check("R5", "lsh ignores b", res_o, 12'h002);
    apply(4'd10, 12'h7FF, 12'hFFF, 1'b0);
    check("R6", "inc ignores b", res_o, 12'h800);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule